// File: doc/BRIEF.md
# Sticky Reset Cause Status Register

This block keeps a record of why the device was last reset. Six cause bits each latch a one-cycle event pulse and hold it until software clears the bit by writing a 1 to it. Software can then read after start-up which of the following caused the reset: a debug-port reset request, a checkstop, a software watchdog expiry, a bus timeout monitor expiry, an external soft reset or an external hard reset.

The 32-bit register uses big-endian bit numbering, so bit 0 is the most significant bit. It is reached over a simple synchronous bus as two 16-bit halfwords. The upper halfword holds only reserved bits. The six cause bits sit at the bottom of the lower halfword. The two external-reset bits come out of reset already set. A checkstop is recorded only while the checkstop-reset enable input is high.

Top module: `rstcause_status`

## Requirements
- R1: While rstN is low and right after it is released, the lower halfword (address LO_OFFSET, default 0x10C92) reads 0x0003 and the upper halfword (address HI_OFFSET, default 0x10C90) reads 0x0000.
- R2: Each event pulse sets its cause bit. The bit is visible from the first clock edge after the pulse. Positions in the lower halfword, with halfword bit 15 being register bit 16: evtDebug is bit 5 (register bit 26), evtStop is bit 4 (27), evtWdog is bit 3 (28), evtBusTmo is bit 2 (29), evtExtSoft is bit 1 (30), evtExtHard is bit 0 (31).
- R3: A set cause bit stays set over any number of cycles until it is cleared by a write.
- R4: A write to the lower halfword clears every cause bit whose wrData bit is 1, from the next edge on. Cause bits whose wrData bit is 0 keep their value.
- R5: evtStop sets halfword bit 4 only when stopRstEn is high in the same cycle. With stopRstEn low the bit is left unchanged.
- R6: When an event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: Lower-halfword bits 15 to 6 and the whole upper halfword always read 0. Writes to these bits, and any write to the upper halfword, change nothing.
- R8: Any address other than the two halfword offsets reads 0x0000. Writes to such an address change no cause bit.
- R9: rdData follows addr and the register state in the same cycle, with no added latency. Reading never changes any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (20) | Byte offset of the halfword being accessed |
| wrEn | input | 1 | Write strobe for the current address |
| wrData | input | 16 | Halfword write data; a 1 clears the matching cause bit |
| rdData | output | 16 | Halfword read data for addr, same cycle |
| evtDebug | input | 1 | Debug-port reset request pulse |
| evtStop | input | 1 | Core checkstop pulse |
| stopRstEn | input | 1 | Allows evtStop to be recorded |
| evtWdog | input | 1 | Software watchdog expiry pulse |
| evtBusTmo | input | 1 | Bus timeout monitor expiry pulse |
| evtExtSoft | input | 1 | External soft-reset pulse |
| evtExtHard | input | 1 | External hard-reset pulse |

## Verification
The bench tries all 64 clear masks on a fully set register and all 64 event patterns with the checkstop enable both low and high. A swapped bit position or a missing enable gate therefore shows up as a wrong bit in some sweep. A design that let a clear win over a same-cycle event would lose that event, and the bench catches this by pulsing every pattern together with an all-ones clear. Writes of all ones to the upper halfword, to unused addresses and to the reserved lower bits, followed by read-back, expose decoders that alias addresses or registers that keep reserved bits. Repeated reads check that reading never clears anything.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int CAUSE_N = 6;
  localparam int HALF_W  = 16;

  // Index of each cause inside the lower halfword (halfword bit i = register bit 31-i)
  localparam int IDX_EXT_HARD = 0;
  localparam int IDX_EXT_SOFT = 1;
  localparam int IDX_BUS_TMO  = 2;
  localparam int IDX_WDOG     = 3;
  localparam int IDX_STOP     = 4;
  localparam int IDX_DEBUG    = 5;

  typedef struct packed {
    logic               selLow;
    logic               selHigh;
    logic [CAUSE_N-1:0] clrMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 20'h10C90,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 20'h10C92
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [HALF_W-1:0] wrData,
  output ctrlStrobes_t      strobes
);
  logic hitLow;
  logic hitHigh;
  logic unusedWrBits;

  assign hitLow  = (addr == LO_OFFSET);
  assign hitHigh = (addr == HI_OFFSET);

  // Reserved write bits are dropped here
  assign unusedWrBits = ^wrData[HALF_W-1:CAUSE_N];

  always_comb begin
    strobes         = '0;
    strobes.selLow  = hitLow;
    strobes.selHigh = hitHigh;
    if (wrEn && hitLow) begin
      strobes.clrMask = wrData[CAUSE_N-1:0];
    end
  end

  // R8: at most one halfword decoded per access
  assert_single_select_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selLow, strobes.selHigh}));

  // R7, R8: clear strobes only come from a lower-halfword write
  assert_clear_only_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrMask != '0) |-> (wrEn && strobes.selLow));
endmodule

// File: rtl/rstcause_dp.sv
module rstcause_dp
  import rstcause_pkg::*;
#(
  parameter logic [CAUSE_N-1:0] CAUSE_RESET = 6'b000011,
  parameter logic [HALF_W-1:0]  HIGH_VALUE  = 16'h0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [CAUSE_N-1:0] evtVec,
  input  logic               stopRstEn,
  output logic [HALF_W-1:0]  rdData
);
  localparam int RSV_W = HALF_W - CAUSE_N;

  logic [CAUSE_N-1:0] setVec;
  logic [CAUSE_N-1:0] causeQ;

  always_comb begin
    setVec           = evtVec;
    setVec[IDX_STOP] = evtVec[IDX_STOP] & stopRstEn;
  end

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rstN) begin
        causeQ[i] <= CAUSE_RESET[i];
      end else if (setVec[i]) begin
        causeQ[i] <= 1'b1;           // set wins over clear
      end else if (strobes.clrMask[i]) begin
        causeQ[i] <= 1'b0;
      end
    end

    // R6: event in the same cycle as a clear still leaves the bit set
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> causeQ[i]);

    // R4: lone clear drops the bit
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrMask[i] && !setVec[i]) |=> !causeQ[i]);

    // R3: with neither set nor clear the bit holds
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.clrMask[i] && !setVec[i]) |=> $stable(causeQ[i]));
  end

  always_comb begin
    if (strobes.selLow) begin
      rdData = {{RSV_W{1'b0}}, causeQ};
    end else if (strobes.selHigh) begin
      rdData = HIGH_VALUE;
    end else begin
      rdData = '0;
    end
  end

  // R5: with the enable low a clear checkstop bit stays clear
  assert_stop_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!causeQ[IDX_STOP] && !stopRstEn) |=> !causeQ[IDX_STOP]);

  // R7: reserved read bits are always zero
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[HALF_W-1:CAUSE_N] == '0);
endmodule

// File: rtl/rstcause_status.sv
module rstcause_status
  import rstcause_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 20'h10C90,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 20'h10C92
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              evtDebug,
  input  logic              evtStop,
  input  logic              stopRstEn,
  input  logic              evtWdog,
  input  logic              evtBusTmo,
  input  logic              evtExtSoft,
  input  logic              evtExtHard
);
  ctrlStrobes_t       strobes;
  logic [CAUSE_N-1:0] evtVec;

  always_comb begin
    evtVec               = '0;
    evtVec[IDX_DEBUG]    = evtDebug;
    evtVec[IDX_STOP]     = evtStop;
    evtVec[IDX_WDOG]     = evtWdog;
    evtVec[IDX_BUS_TMO]  = evtBusTmo;
    evtVec[IDX_EXT_SOFT] = evtExtSoft;
    evtVec[IDX_EXT_HARD] = evtExtHard;
  end

  rstcause_ctrl #(
    .ADDR_W   (ADDR_W),
    .HI_OFFSET(HI_OFFSET),
    .LO_OFFSET(LO_OFFSET)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobes(strobes)
  );

  rstcause_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .evtVec   (evtVec),
    .stopRstEn(stopRstEn),
    .rdData   (rdData)
  );

  // R8: unmatched addresses read zero
  assert_other_addr_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addr != LO_OFFSET) |-> (rdData == 16'h0000));
endmodule

// File: tb/rstcause_status_bench.sv
module rstcause_status_bench;
  localparam logic [19:0] HI = 20'h10C90;
  localparam logic [19:0] LO = 20'h10C92;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [19:0] addr = LO;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic evtDebug = 0, evtStop = 0, stopRstEn = 0, evtWdog = 0;
  logic evtBusTmo = 0, evtExtSoft = 0, evtExtHard = 0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rstcause_status u_rstcause_status (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evtDebug(evtDebug), .evtStop(evtStop),
    .stopRstEn(stopRstEn), .evtWdog(evtWdog), .evtBusTmo(evtBusTmo),
    .evtExtSoft(evtExtSoft), .evtExtHard(evtExtHard)
  );

  task automatic check(input string req, input logic [19:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  // pattern bit i drives the event at lower-halfword bit i
  task automatic pulse(input logic [5:0] p, input logic en,
                       input logic doWr, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    evtExtHard = p[0]; evtExtSoft = p[1]; evtBusTmo = p[2];
    evtWdog = p[3]; evtStop = p[4]; evtDebug = p[5]; stopRstEn = en;
    wrEn = doWr; addr = a; wrData = d;
    @(negedge clk);
    {evtExtHard, evtExtSoft, evtBusTmo, evtWdog, evtStop, evtDebug} = '0;
    stopRstEn = 0; wrEn = 0; addr = LO;
  endtask

  task automatic clearAll();
    pulse(6'h00, 1'b0, 1'b1, LO, 16'hFFFF);
  endtask

  task automatic setAll();
    pulse(6'h3F, 1'b1, 1'b0, LO, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", LO, 16'h0003);
    check("R1", HI, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", LO, 16'h0003);
    check("R1", HI, 16'h0000);

    // R4: every clear mask on a full register, reserved bits written as ones
    for (int m = 0; m < 64; m++) begin
      setAll();
      check("R2", LO, 16'h003F);
      pulse(6'h00, 1'b0, 1'b1, LO, 16'hFFC0 | 16'(m));
      check("R4", LO, 16'(6'h3F & ~6'(m)));
    end

    // R2/R5: every event pattern, enable low and high
    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 64; p++) begin
        clearAll();
        pulse(6'(p), 1'(en), 1'b0, LO, 16'h0000);
        check(en ? "R2" : "R5", LO, 16'(en ? 6'(p) : (6'(p) & 6'h2F)));
      end
    end

    // R5: checkstop with enable low leaves a set bit set
    setAll();
    pulse(6'h10, 1'b0, 1'b0, LO, 16'h0000);
    check("R5", LO, 16'h003F);

    // R6: event together with an all-ones clear
    for (int p = 0; p < 64; p++) begin
      clearAll();
      pulse(6'(p), 1'b1, 1'b1, LO, 16'h003F);
      check("R6", LO, 16'(p));
    end

    // R3: bits hold over many idle cycles
    clearAll();
    pulse(6'h2A, 1'b1, 1'b0, LO, 16'h0000);
    repeat (50) @(negedge clk);
    check("R3", LO, 16'h002A);

    // R9: repeated reads clear nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9", LO, 16'h002A);
      check("R9", HI, 16'h0000);
    end

    // R7: writes to the upper halfword change nothing
    setAll();
    pulse(6'h00, 1'b0, 1'b1, HI, 16'hFFFF);
    check("R7", HI, 16'h0000);
    check("R7", LO, 16'h003F);

    // R8: writes to other addresses are ignored, reads give zero
    for (int k = 0; k < 8; k++) begin
      logic [19:0] a;
      a = (k < 4) ? (LO + 20'(2 * (k + 1))) : (HI - 20'(2 * (k - 3)));
      if (k == 0) a = LO + 20'd1;
      pulse(6'h00, 1'b0, 1'b1, a, 16'hFFFF);
      check("R8", a, 16'h0000);
      check("R8", LO, 16'h003F);
    end

    // R1: reset mid-run restores the start values
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1", LO, 16'h0003);
    clearAll();
    check("R4", LO, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule